// File: doc/BRIEF.md
# Level-2 cache controller register stub

This block occupies the register window of a level-2 cache controller in systems that need that window to answer but have no cache behind it. It sits on an APB slave port with 32-bit transfers and no wait states. It returns a fixed identity word and keeps the control, auxiliary control, tag latency, data latency and address filter registers. It also reports a cache type word whose geometry fields follow the auxiliary control register. Maintenance-operation offsets always read as finished.

The cache type word lives in a register. Each read of it ORs a geometry mask, derived from auxiliary control, into that register. Bits set this way stay set until reset. Unmapped offsets read as zero, drop writes, and assert the slave error signal for the one access cycle of that transfer.

Top module: `l2stub_regs`

## Requirements
- R1: After reset, control, tag latency, data latency, filter low and filter high read 0, auxiliary control reads 0x02020000 and the cache type reads its parameter default 0x1C100100. A later reset reloads that default, which clears any bits that had stuck.
- R2: Offset 0x000 always reads 0x410000C8. Writes to 0x000 or 0x004 change nothing and assert the error signal.
- R3: A write to control at 0x100 keeps only write-data bit 0, so the readback has bits 31:1 at zero.
- R4: Auxiliary control (0x104), tag latency (0x108), data latency (0x10C), filter low (0xC00) and filter high (0xC04) each store and return the full 32-bit write word.
- R5: A read of 0x004 returns C = T | (v << 18) | (v << 6) and stores C back into T. Here T is the stored type word and v is a 5-bit value with v[4:2] = aux[19:17], v[1] = 0 and v[0] = aux[16]. Bits set this way stay set when aux changes later.
- R6: The type register changes only on the access-phase edge of a read of 0x004, once per transfer. Reads of other offsets, writes, and a setup phase that is never followed by an access leave it unchanged.
- R7: Any offset from 0x730 through 0x7FF reads 0. Writes there are dropped and raise no error.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read 0, drop writes and raise no error.
- R9: Every other offset reads 0, drops writes and asserts the error signal in the access phase.
- R10: Only address bits 11:0 are decoded, so the window repeats every 4 KB.
- R11: The ready signal is always high. The error signal is high only in the access phase of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits 11:0 decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read transfer |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for unmapped or read-only offsets |

## Verification
The type-word logic is tried with three auxiliary patterns. The reset value adds nothing new to the type word. The pattern 0x000F0000 sets every geometry bit. The pattern 0x00010000 sets only the lowest bit. Comparing these shows whether the mask bits land in the right places and whether they stick once aux is cleared. A separate sequence changes aux with no type read in between, and one of its transfers is abandoned after the setup phase. If a stray update happened there, the next read would differ from the default. The edges of the decode are probed on both sides: 0x72C, 0x730, 0x7FF and 0x800. Aliases above 4 KB are also read, to show that only the low 12 bits select the register.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;
  localparam int DW    = 32;
  localparam int OFS_W = 12;

  typedef enum logic [3:0] {
    RG_ID, RG_CTYPE, RG_CTRL, RG_AUX, RG_TAGLAT, RG_DATLAT,
    RG_FLO, RG_FHI, RG_MAINT, RG_RAZ, RG_BAD
  } region_e;

  localparam logic [OFS_W-1:0] OFS_ID       = 12'h000;
  localparam logic [OFS_W-1:0] OFS_CTYPE    = 12'h004;
  localparam logic [OFS_W-1:0] OFS_CTRL     = 12'h100;
  localparam logic [OFS_W-1:0] OFS_AUX      = 12'h104;
  localparam logic [OFS_W-1:0] OFS_TAGLAT   = 12'h108;
  localparam logic [OFS_W-1:0] OFS_DATLAT   = 12'h10C;
  localparam logic [OFS_W-1:0] OFS_FLO      = 12'hC00;
  localparam logic [OFS_W-1:0] OFS_FHI      = 12'hC04;
  localparam logic [OFS_W-1:0] OFS_MAINT_LO = 12'h730;
  localparam logic [OFS_W-1:0] OFS_MAINT_HI = 12'h800;
  localparam logic [OFS_W-1:0] OFS_RAZ0     = 12'hF40;
  localparam logic [OFS_W-1:0] OFS_RAZ1     = 12'hF60;
  localparam logic [OFS_W-1:0] OFS_RAZ2     = 12'hF80;

  // Geometry mask that a type read ORs into the stored type word
  function automatic logic [DW-1:0] ctype_geom(input logic [DW-1:0] aux);
    logic [DW-1:0] v;
    v = '0;
    v[4:0] = {aux[19:17], 1'b0, aux[16]};
    return (v << 18) | (v << 6);
  endfunction
endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
  import l2stub_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  output region_e          region
);
  always_comb begin
    region = RG_BAD;
    if (ofs >= OFS_MAINT_LO && ofs < OFS_MAINT_HI) begin
      region = RG_MAINT;
    end else begin
      case (ofs)
        OFS_ID:     region = RG_ID;
        OFS_CTYPE:  region = RG_CTYPE;
        OFS_CTRL:   region = RG_CTRL;
        OFS_AUX:    region = RG_AUX;
        OFS_TAGLAT: region = RG_TAGLAT;
        OFS_DATLAT: region = RG_DATLAT;
        OFS_FLO:    region = RG_FLO;
        OFS_FHI:    region = RG_FHI;
        OFS_RAZ0, OFS_RAZ1, OFS_RAZ2: region = RG_RAZ;
        default:    region = RG_BAD;
      endcase
    end
  end
endmodule

// File: rtl/l2stub_regfile.sv
module l2stub_regfile
  import l2stub_pkg::*;
#(
  parameter logic [DW-1:0] AUX_RESET = 32'h0202_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  region_e       region,
  input  logic [DW-1:0] wdata,
  output logic          ctrl_q,
  output logic [DW-1:0] aux_q,
  output logic [DW-1:0] taglat_q,
  output logic [DW-1:0] datlat_q,
  output logic [DW-1:0] flo_q,
  output logic [DW-1:0] fhi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= 1'b0;
      aux_q    <= AUX_RESET;
      taglat_q <= '0;
      datlat_q <= '0;
      flo_q    <= '0;
      fhi_q    <= '0;
    end else if (wr_acc) begin
      case (region)
        RG_CTRL:   ctrl_q   <= wdata[0];
        RG_AUX:    aux_q    <= wdata;
        RG_TAGLAT: taglat_q <= wdata;
        RG_DATLAT: datlat_q <= wdata;
        RG_FLO:    flo_q    <= wdata;
        RG_FHI:    fhi_q    <= wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/l2stub_ctype.sv
module l2stub_ctype
  import l2stub_pkg::*;
#(
  parameter logic [DW-1:0] CTYPE_DEFAULT = 32'h1C10_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hit,
  input  logic [DW-1:0] aux,
  output logic [DW-1:0] ctype_q,
  output logic [DW-1:0] ctype_view
);
  assign ctype_view = ctype_q | ctype_geom(aux);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctype_q <= CTYPE_DEFAULT;
    else if (rd_hit) ctype_q <= ctype_view;
  end
endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
  import l2stub_pkg::*;
#(
  parameter int            ADDR_W        = 32,
  parameter logic [31:0]   ID_WORD       = 32'h4100_00C8,
  parameter logic [31:0]   CTYPE_DEFAULT = 32'h1C10_0100,
  parameter logic [31:0]   AUX_RESET     = 32'h0202_0000
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr
);
  region_e       region;
  logic          acc_phase, wr_acc, rd_ctype_acc, rd_setup_or_acc;
  logic          ctrl_q;
  logic [DW-1:0] aux_q, taglat_q, datlat_q, flo_q, fhi_q;
  logic [DW-1:0] ctype_q, ctype_view;
  logic          unused_hi_bits;

  assign unused_hi_bits = ^paddr[ADDR_W-1:OFS_W];

  l2stub_decode u_dec (.ofs(paddr[OFS_W-1:0]), .region(region));

  assign acc_phase       = psel && penable;
  assign wr_acc          = acc_phase && pwrite;
  assign rd_ctype_acc    = acc_phase && !pwrite && (region == RG_CTYPE);
  assign rd_setup_or_acc = psel && !pwrite;

  l2stub_regfile #(.AUX_RESET(AUX_RESET)) u_rf (
    .clk(pclk), .rst_n(presetn), .wr_acc(wr_acc), .region(region),
    .wdata(pwdata), .ctrl_q(ctrl_q), .aux_q(aux_q), .taglat_q(taglat_q),
    .datlat_q(datlat_q), .flo_q(flo_q), .fhi_q(fhi_q)
  );

  l2stub_ctype #(.CTYPE_DEFAULT(CTYPE_DEFAULT)) u_ct (
    .clk(pclk), .rst_n(presetn), .rd_hit(rd_ctype_acc), .aux(aux_q),
    .ctype_q(ctype_q), .ctype_view(ctype_view)
  );

  always_comb begin
    prdata = '0;
    if (rd_setup_or_acc) begin
      case (region)
        RG_ID:     prdata = ID_WORD;
        RG_CTYPE:  prdata = ctype_view;
        RG_CTRL:   prdata = {{(DW-1){1'b0}}, ctrl_q};
        RG_AUX:    prdata = aux_q;
        RG_TAGLAT: prdata = taglat_q;
        RG_DATLAT: prdata = datlat_q;
        RG_FLO:    prdata = flo_q;
        RG_FHI:    prdata = fhi_q;
        default:   prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = acc_phase &&
                   ((region == RG_BAD) ||
                    (pwrite && (region == RG_ID || region == RG_CTYPE)));
endmodule

// File: rtl/l2stub_chk.sv
module l2stub_chk
  import l2stub_pkg::*;
(
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [31:0]   pwdata,
  input logic [31:0]   prdata,
  input logic          pslverr,
  input region_e       region,
  input logic [DW-1:0] aux_q,
  input logic [DW-1:0] ctype_q
);
  AST_ERR_ONLY_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (psel && penable)); // R11

  AST_BAD_FLAGS_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && region == RG_BAD) |-> (pslverr && prdata == 32'h0)); // R9

  AST_MAINT_DONE: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && region == RG_MAINT) |-> (!pslverr && prdata == 32'h0)); // R7

  AST_CTRL_ONE_BIT: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && region == RG_CTRL) |-> (prdata[31:1] == 31'h0)); // R3

  AST_AUX_STORES: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && region == RG_AUX) |=> (aux_q == $past(pwdata))); // R4

  AST_CTYPE_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    ((ctype_q & $past(ctype_q)) == $past(ctype_q))); // R5

  AST_CTYPE_ONLY_ON_READ: assert property (@(posedge pclk) disable iff (!presetn)
    !(psel && penable && !pwrite && region == RG_CTYPE) |=> $stable(ctype_q)); // R6
endmodule

bind l2stub_regs l2stub_chk u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
  .region(region), .aux_q(aux_q), .ctype_q(ctype_q)
);

// File: tb/l2stub_regs_bench.sv
module l2stub_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          is_rd;
    logic [31:0] exp_d;
    bit          exp_e;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [31:0] aux_m;
  logic [31:0] ctype_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2stub_regs u_l2stub_regs (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr)
  );

  // Geometry bits written out one by one, as listed in R5
  function automatic logic [31:0] geom_ref(input logic [31:0] a);
    logic [31:0] m;
    m = '0;
    m[22] = a[19]; m[21] = a[18]; m[20] = a[17]; m[18] = a[16];
    m[10] = a[19]; m[9]  = a[18]; m[8]  = a[17]; m[6]  = a[16];
    return m;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: checks each access phase against the next expected item
  always @(negedge clk) begin
    if (psel && penable && !done) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard: actual access expected none");
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.is_rd) chk({it.tag, " data"}, prdata, it.exp_d);
        chk({it.tag, " err"}, {31'h0, pslverr}, {31'h0, it.exp_e});
        chk("R11 ready", {31'h0, pready}, 32'h1);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0; psel = 0; penable = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    aux_m = 32'h0202_0000;
    ctype_m = 32'h1C10_0100;
  endtask

  task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                      input logic [31:0] ed, input bit ee, input string tag);
    item_t it;
    it.is_rd = !wr; it.exp_d = ed; it.exp_e = ee; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk); chk("R11 no err in setup", {31'h0, pslverr}, 32'h0);
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit ee, input string tag);
    xfer(1, a, d, 32'h0, ee, tag);
    if (!ee && a[11:0] == 12'h104) aux_m = d;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] ed, input bit ee, input string tag);
    xfer(0, a, 32'h0, ed, ee, tag);
  endtask

  task automatic rd_type(input string tag);
    ctype_m = ctype_m | geom_ref(aux_m);
    rd(32'h004, ctype_m, 0, tag);
  endtask

  initial begin
    do_reset();
    // R1 / R2: reset values and identity
    rd(32'h000, 32'h4100_00C8, 0, "R2 id");
    rd_type("R1 type default");
    rd(32'h100, 32'h0, 0, "R1 ctrl");
    rd(32'h104, 32'h0202_0000, 0, "R1 aux");
    rd(32'h108, 32'h0, 0, "R1 tag");
    rd(32'h10C, 32'h0, 0, "R1 data");
    rd(32'hC00, 32'h0, 0, "R1 flo");
    rd(32'hC04, 32'h0, 0, "R1 fhi");
    // R3: control keeps one bit
    wr(32'h100, 32'hFFFF_FFFF, 0, "R3 wr");
    rd(32'h100, 32'h1, 0, "R3 ctrl all ones");
    wr(32'h100, 32'hFFFF_FFFE, 0, "R3 wr");
    rd(32'h100, 32'h0, 0, "R3 ctrl bit0 clear");
    // R4: full-width registers
    wr(32'h108, 32'hA5A5_5A5A, 0, "R4 wr");
    wr(32'h10C, 32'h1234_5678, 0, "R4 wr");
    wr(32'hC00, 32'hDEAD_BEEF, 0, "R4 wr");
    wr(32'hC04, 32'hFFFF_0001, 0, "R4 wr");
    rd(32'h108, 32'hA5A5_5A5A, 0, "R4 tag");
    rd(32'h10C, 32'h1234_5678, 0, "R4 data");
    rd(32'hC00, 32'hDEAD_BEEF, 0, "R4 flo");
    rd(32'hC04, 32'hFFFF_0001, 0, "R4 fhi");
    // R5: geometry mask and stickiness
    wr(32'h104, 32'h000F_0000, 0, "R5 aux");
    rd(32'h104, 32'h000F_0000, 0, "R4 aux");
    rd_type("R5 all geometry bits");
    wr(32'h104, 32'h0, 0, "R5 aux clear");
    rd_type("R5 bits stay set");
    // R1: reset reloads default
    do_reset();
    rd_type("R1 type reloaded");
    // R6: no update without a type read; abandoned setup phase
    wr(32'h104, 32'h0001_0000, 0, "R6 aux");
    @(posedge clk); #1 psel = 1; penable = 0; pwrite = 0; paddr = 32'h004;
    @(posedge clk); #1 psel = 0;
    rd(32'h000, 32'h4100_00C8, 0, "R6 other read");
    wr(32'h104, 32'h0202_0000, 0, "R6 aux back");
    rd(32'h004, 32'h1C10_0100, 0, "R6 type unchanged");
    // R7: maintenance window
    wr(32'h100, 32'h1, 0, "R7 set ctrl");
    wr(32'h730, 32'hFFFF_FFFF, 0, "R7 wr lo");
    wr(32'h7FC, 32'hFFFF_FFFF, 0, "R7 wr hi");
    rd(32'h730, 32'h0, 0, "R7 rd 0x730");
    rd(32'h7FF, 32'h0, 0, "R7 rd 0x7FF");
    rd(32'h100, 32'h1, 0, "R7 ctrl untouched");
    // R8: read-as-zero offsets
    wr(32'hF40, 32'h1, 0, "R8 wr F40");
    wr(32'hF60, 32'h1, 0, "R8 wr F60");
    wr(32'hF80, 32'h1, 0, "R8 wr F80");
    rd(32'hF40, 32'h0, 0, "R8 rd F40");
    rd(32'hF60, 32'h0, 0, "R8 rd F60");
    rd(32'hF80, 32'h0, 0, "R8 rd F80");
    // R9: unmapped offsets, both window edges
    rd(32'h72C, 32'h0, 1, "R9 rd 0x72C");
    rd(32'h800, 32'h0, 1, "R9 rd 0x800");
    rd(32'h200, 32'h0, 1, "R9 rd 0x200");
    wr(32'h110, 32'hFFFF_FFFF, 1, "R9 wr 0x110");
    rd(32'h100, 32'h1, 0, "R9 ctrl untouched");
    // R2: read-only words reject writes
    wr(32'h000, 32'h0, 1, "R2 wr id");
    wr(32'h004, 32'hFFFF_FFFF, 1, "R2 wr type");
    rd(32'h000, 32'h4100_00C8, 0, "R2 id kept");
    rd(32'h004, 32'h1C10_0100, 0, "R2 type kept");
    // R10: aliasing above 4 KB
    wr(32'h0000_1104, 32'h0055_0000, 0, "R10 wr alias");
    rd(32'h0000_0104, 32'h0055_0000, 0, "R10 rd base");
    rd(32'hFFFF_F000, 32'h4100_00C8, 0, "R10 id alias");
    repeat (3) @(posedge clk);
    chk("scoreboard empty", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule